// File: doc/BRIEF.md
# MAC Interrupt Status and Event Counter Unit

This unit sits beside an Ethernet MAC and gathers its event strobes into a few registers. Three 8-bit statistics counters track missed frames, runt frames and receive collisions. An 8-bit status register latches interrupt causes. An 8-bit mask register picks which of those causes may drive the single interrupt line. Software reaches all five registers over a small register bus that has an address, a read strobe, a write strobe and write data. Read data is combinational and is valid while the read strobe is high.

The counters and the status register clear themselves at the clock edge that ends a bus read. An event that arrives in the same cycle as that read is kept, so no event is lost. When a counter rolls over from all ones to zero, it sets its own overflow cause in the status register.

The interrupt line is driven by a two-state machine. The states are `IRQ_IDLE` and `IRQ_RAISED`. On each clock edge the machine moves from `IRQ_IDLE` to `IRQ_RAISED` when any unmasked status bit is set (the raise transition). It moves from `IRQ_RAISED` back to `IRQ_IDLE` when no unmasked status bit is set (the drop transition). In every other case it stays where it is (the hold transitions). The line is high in `IRQ_RAISED` only.

Top module: `mac_irq_stats`

## Requirements
- R1: After reset the three counters and the status register read 0x00, the mask register reads 0xFF and `irq` is low.
- R2: Each edge with `ev_missed`, `ev_runt` or `ev_rxcoll` high adds one to its counter. The counters sit at address 2 (missed), 3 (runt) and 4 (receive collision).
- R3: A counter at 0xFF that takes one more event goes to 0x00. At that same edge it sets its overflow bit in the status register: 0x04 for missed, 0x08 for runt, 0x10 for receive collision. No overflow bit is set before the wrap.
- R4: A bus read of a counter returns its value and clears it. If that counter's strobe is high in the same cycle, the counter is left at 0x01 instead.
- R5: The status register (address 0) latches the direct causes: `ev_jabber` 0x80, `ev_babble` 0x40, `ev_cerr` 0x20, `ev_rxdone` 0x02, `ev_txdone` 0x01. A latched bit stays set until a read.
- R6: A bus read of the status register returns its value and clears it. A cause that fires in the same cycle stays set after the read.
- R7: The mask register (address 1) is written and read back over the bus. A mask bit of 1 blocks its cause from `irq`, but the status bit still latches.
- R8: `irq` goes high one edge after an unmasked status bit becomes visible, so two edges after the strobe. It goes low one edge after no unmasked bit remains.
- R9: Writes to the status register and to the counters change nothing.
- R10: Addresses 5 to 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_missed | input | 1 | Missed-frame strobe |
| ev_runt | input | 1 | Runt-frame strobe |
| ev_rxcoll | input | 1 | Receive-collision strobe |
| ev_jabber | input | 1 | Jabber cause strobe |
| ev_babble | input | 1 | Babble cause strobe |
| ev_cerr | input | 1 | Missing-heartbeat cause strobe |
| ev_rxdone | input | 1 | Receive-done cause strobe |
| ev_txdone | input | 1 | Transmit-done cause strobe |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, clears the addressed self-clearing register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives event strobes in the same cycle as a read of the same register. A design that cleared last would lose the event, and one that cleared first would return a wrong value.

It runs all three counters through 255 events and checks that no overflow bit is set yet. It then sends the 256th event and expects the counters at zero with exactly 0x1C latched. An off-by-one wrap or a late flag would show up here.

It measures the `irq` latency edge by edge, both on the way up and on the way down after a clearing read. A masked cause must still latch its status bit, and writes to the status register and the counters must leave them unchanged.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
    localparam int REG_W = 8;

    // register addresses
    localparam int ADDR_STATUS   = 0;
    localparam int ADDR_MASK     = 1;
    localparam int ADDR_CNT_BASE = 2;   // missed, runt, rx collision follow in order
    localparam int NUM_CNT       = 3;

    // status bit positions
    localparam int BIT_TXDONE   = 0;
    localparam int BIT_RXDONE   = 1;
    localparam int BIT_OVF_BASE = 2;    // overflow bit of counter k is BIT_OVF_BASE + k
    localparam int BIT_CERR     = 5;
    localparam int BIT_BABBLE   = 6;
    localparam int BIT_JABBER   = 7;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_RAISED
    } irq_state_e;
endpackage

// File: rtl/mac_evt_counter.sv
module mac_evt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] MAXV = '1;

    assign wrap = evt && !clr && (count == MAXV);

    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= evt ? W'(1) : '0;
        else if (evt)    count <= count + W'(1);
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !evt |=> count == '0);                                // R4
    AST_CLR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        clr && evt |=> count == W'(1));                              // R4
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt && !clr && count == MAXV |=> count == '0);               // R3
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic             rd_clr,
    input  logic             mask_we,
    input  logic [REG_W-1:0] mask_wdata,
    output logic [REG_W-1:0] status,
    output logic [REG_W-1:0] mask
);
    logic [REG_W-1:0] status_d;

    always_comb begin
        status_d = (rd_clr ? '0 : status) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= status_d;
            if (mask_we) mask <= mask_wdata;
        end
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (status & $past(status)) == $past(status));      // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));                                 // R7
endmodule

// File: rtl/mac_irq_fsm.sv
module mac_irq_fsm
    import mac_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    irq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE:   if (pending)  state_nx = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_nx = IRQ_IDLE;
            default:    state_nx = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state == IRQ_RAISED);
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq);                                            // R8
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq);                                          // R8
endmodule

// File: rtl/mac_irq_stats.sv
module mac_irq_stats
    import mac_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_missed,
    input  logic              ev_runt,
    input  logic              ev_rxcoll,
    input  logic              ev_jabber,
    input  logic              ev_babble,
    input  logic              ev_cerr,
    input  logic              ev_rxdone,
    input  logic              ev_txdone,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    logic [NUM_CNT-1:0] cnt_evt;
    logic [NUM_CNT-1:0] cnt_clr;
    logic [NUM_CNT-1:0] cnt_wrap;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic [REG_W-1:0]   set_vec;
    logic [REG_W-1:0]   status;
    logic [REG_W-1:0]   mask;
    logic               sel_status;
    logic               sel_mask;
    logic               pending;

    assign cnt_evt    = {ev_rxcoll, ev_runt, ev_missed};
    assign sel_status = (bus_addr == ADDR_W'(ADDR_STATUS));
    assign sel_mask   = (bus_addr == ADDR_W'(ADDR_MASK));

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        assign cnt_clr[k] = bus_rd && (bus_addr == ADDR_W'(ADDR_CNT_BASE + k));
        mac_evt_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (cnt_evt[k]),
            .clr   (cnt_clr[k]),
            .count (cnt_val[k]),
            .wrap  (cnt_wrap[k])
        );
        AST_OVF_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_wrap[k] |=> status[BIT_OVF_BASE + k]);               // R3
    end

    always_comb begin
        set_vec = '0;
        set_vec[BIT_JABBER] = ev_jabber;
        set_vec[BIT_BABBLE] = ev_babble;
        set_vec[BIT_CERR]   = ev_cerr;
        set_vec[BIT_RXDONE] = ev_rxdone;
        set_vec[BIT_TXDONE] = ev_txdone;
        for (int k = 0; k < NUM_CNT; k++) set_vec[BIT_OVF_BASE + k] = cnt_wrap[k];
    end

    mac_irq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .rd_clr     (bus_rd && sel_status),
        .mask_we    (bus_wr && sel_mask),
        .mask_wdata (bus_wdata),
        .status     (status),
        .mask       (mask)
    );

    assign pending = |(status & ~mask);

    mac_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_status)    bus_rdata = status;
        else if (sel_mask) bus_rdata = mask;
        for (int k = 0; k < NUM_CNT; k++)
            if (bus_addr == ADDR_W'(ADDR_CNT_BASE + k)) bus_rdata = 8'(cnt_val[k]);
    end

    AST_STATUS_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && sel_status && !bus_rd && set_vec == '0
        |=> status == $past(status));                                // R9
endmodule

// File: tb/test_mac_irq_stats.sv
module test_mac_irq_stats;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ev_missed = 0, ev_runt = 0, ev_rxcoll = 0;
    logic       ev_jabber = 0, ev_babble = 0, ev_cerr = 0;
    logic       ev_rxdone = 0, ev_txdone = 0;
    logic [2:0] bus_addr = 0;
    logic       bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2 clk = ~clk;

    mac_irq_stats i_mac_irq_stats (
        .clk(clk), .rst_n(rst_n),
        .ev_missed(ev_missed), .ev_runt(ev_runt), .ev_rxcoll(ev_rxcoll),
        .ev_jabber(ev_jabber), .ev_babble(ev_babble), .ev_cerr(ev_cerr),
        .ev_rxdone(ev_rxdone), .ev_txdone(ev_txdone),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic note(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected read value per read cycle
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            if (exp_q.size() == 0) note(0, "scoreboard-empty", bus_rdata, 0);
            else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                note(bus_rdata === e, r, bus_rdata, e);
            end
        end
    end

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string r);
        exp_q.push_back(e);
        req_q.push_back(r);
        bus_addr = a;
        bus_rd = 1;
        cycle();
        bus_rd = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1;
        cycle();
        bus_wr = 0;
    endtask

    task automatic chk_irq(input logic e, input string r);
        note(irq === e, r, irq, e);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        // R1 reset state
        chk_irq(0, "R1");
        rd(0, 8'h00, "R1");
        rd(1, 8'hFF, "R1");
        rd(2, 8'h00, "R1");
        rd(3, 8'h00, "R1");
        rd(4, 8'h00, "R1");
        // R2 counting, R4 clear
        ev_missed = 1; repeat (3) cycle(); ev_missed = 0;
        ev_runt = 1; cycle(); ev_runt = 0;
        ev_rxcoll = 1; repeat (2) cycle(); ev_rxcoll = 0;
        rd(2, 8'd3, "R2");
        rd(2, 8'd0, "R4");
        rd(3, 8'd1, "R2");
        rd(4, 8'd2, "R2");
        rd(4, 8'd0, "R4");
        // R3 wrap on all three counters
        ev_missed = 1; ev_runt = 1; ev_rxcoll = 1;
        repeat (255) cycle();
        ev_missed = 0; ev_runt = 0; ev_rxcoll = 0;
        rd(0, 8'h00, "R3");           // no early overflow
        ev_missed = 1; ev_runt = 1; ev_rxcoll = 1;
        cycle();
        ev_missed = 0; ev_runt = 0; ev_rxcoll = 0;
        rd(0, 8'h1C, "R3");
        rd(2, 8'h00, "R3");
        rd(3, 8'h00, "R3");
        rd(4, 8'h00, "R3");
        // R4 event during clearing read
        ev_missed = 1; repeat (2) cycle();
        rd(2, 8'd2, "R4");            // strobe still high during read
        ev_missed = 0;
        rd(2, 8'd1, "R4");
        // R5 direct causes
        ev_jabber = 1; cycle(); ev_jabber = 0;
        ev_babble = 1; cycle(); ev_babble = 0;
        ev_cerr = 1; cycle(); ev_cerr = 0;
        ev_rxdone = 1; cycle(); ev_rxdone = 0;
        ev_txdone = 1; cycle(); ev_txdone = 0;
        cycle();
        rd(0, 8'hE3, "R5");
        rd(0, 8'h00, "R6");
        // R6 cause during status read
        ev_txdone = 1; cycle(); ev_txdone = 0;
        ev_rxdone = 1;
        rd(0, 8'h01, "R6");
        ev_rxdone = 0;
        rd(0, 8'h02, "R6");
        // R7 mask write/readback
        wr(1, 8'hFE);
        rd(1, 8'hFE, "R7");
        // R8 latency up and down
        ev_txdone = 1; cycle(); ev_txdone = 0;
        chk_irq(0, "R8");
        cycle();
        chk_irq(1, "R8");
        rd(0, 8'h01, "R8");
        chk_irq(1, "R8");
        cycle();
        chk_irq(0, "R8");
        // R7 masked cause latches but keeps irq low
        ev_rxdone = 1; cycle(); ev_rxdone = 0;
        cycle(); cycle();
        chk_irq(0, "R7");
        rd(0, 8'h02, "R7");
        // R9 writes ignored
        ev_missed = 1; cycle(); ev_missed = 0;
        wr(0, 8'hFF);
        wr(2, 8'h55);
        cycle();
        chk_irq(0, "R9");
        rd(0, 8'h00, "R9");
        rd(2, 8'h01, "R9");
        // R10 unused addresses
        rd(5, 8'h00, "R10");
        rd(6, 8'h00, "R10");
        rd(7, 8'h00, "R10");
        cycle();
        if (exp_q.size() != 0) note(0, "scoreboard-left", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule